// File: doc/BRIEF.md
# Layered Mixer Control Register Bank

This block holds the runtime settings of a video mixer that composites up to seven overlay layers on a base layer. A host reads and writes 32-bit words through a simple synchronous port. Each overlay layer has seven settings:

- an enable mode word
- a blend selector
- a static alpha
- horizontal and vertical placement
- width
- height

Host writes land in a shadow copy of these settings. The compositing datapath only ever sees a separate active copy.

The active copy changes only at a field boundary. A write to the commit word arms a transfer, and the next field-start strobe copies every shadow setting into the active copy at once. A frame therefore never mixes old and new settings. A status word combines three things: the datapath's busy flag, the per-layer running flags, and a pending flag that tells the host that written settings have not yet reached the datapath. Two read-only words report the layer count and the number of pixels handled per clock.

Top module: `mix_ctrl_regs`

## Requirements
- R1: After reset every shadow and active layer setting is zero, the pending flag is clear, and a read of any layer setting returns 0.
- R2: Layer n (1 to NUM_LAYERS) has its settings at byte address 0x148 + (n-1)*0x1C + 4*k, where k = 0 to 6 selects mode (3 bits), blend (2 bits), alpha (ALPHA_W bits), horizontal offset, vertical offset, width and height (16 bits each). A write stores only those low bits, and a read returns them with the upper bits zero. Bits 1:0 of the address are ignored.
- R3: A write to any layer setting sets status bit 1 (pending) from the next cycle on.
- R4: A write of any data to byte address 0x144 arms a transfer. The data is ignored, and the active settings do not change before a field boundary.
- R5: At the first cycle with fieldStart high after the commit write, all active settings take the shadow values. In that same cycle the pending flag and the arming clear.
- R6: A commit write in the same cycle as fieldStart takes effect at that boundary.
- R7: A layer write in the same cycle as an applying boundary lands in the shadow copy only. The active copy takes the values from before the write, and pending stays set.
- R8: The status word at 0x140 reads fieldBusy on bit 0, pending on bit 1, and the running flag of layer n on bit 7+n. All other bits read 0.
- R9: Address 0x000 reads NUM_LAYERS+1 (the layer count including the base), and 0x004 reads PIX_PER_CLK.
- R10: Reads of unmapped addresses return 0. Writes to read-only or unmapped addresses change no setting and do not set pending.
- R11: regRdData takes the addressed word one cycle after a cycle with regRdEn high, and holds its value otherwise.
- R12: A fieldStart without a preceding commit write changes no active setting and leaves pending as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 12 | Byte address of the accessed word |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 32 | Write data |
| regRdEn | input | 1 | Read strobe |
| regRdData | output | 32 | Read data, registered |
| fieldStart | input | 1 | One-cycle strobe at each field boundary |
| fieldBusy | input | 1 | Datapath is processing a field |
| layerRunning | input | NUM_LAYERS | Per-layer running flags from the datapath |
| actMode | output | NUM_LAYERS*3 | Active mode word per layer |
| actBlend | output | NUM_LAYERS*2 | Active blend selector per layer |
| actAlpha | output | NUM_LAYERS*ALPHA_W | Active static alpha per layer |
| actHOffset | output | NUM_LAYERS*16 | Active horizontal offset per layer |
| actVOffset | output | NUM_LAYERS*16 | Active vertical offset per layer |
| actWidth | output | NUM_LAYERS*16 | Active width per layer |
| actHeight | output | NUM_LAYERS*16 | Active height per layer |

## Verification
Two pairs of events can fall in the same cycle: the arming commit and the field boundary, and the field boundary and a host write to a layer setting. The bench drives the commit and fieldStart together, then fieldStart together with a layer write after an earlier commit. A behavioural model compares every active output and the read data on each clock. The model judges that the boundary applies at once in the first case. In the second, it judges that the active copy takes the value from before the write while the status word still shows pending.

// File: rtl/mix_regs_pkg.sv
package mix_regs_pkg;

  localparam int MAX_LAYERS = 7;
  localparam int ADDR_W     = 12;

  localparam logic [ADDR_W-1:0] NLAYER_ADDR  = 12'h000;
  localparam logic [ADDR_W-1:0] PIXPAR_ADDR  = 12'h004;
  localparam logic [ADDR_W-1:0] STATUS_ADDR  = 12'h140;
  localparam logic [ADDR_W-1:0] COMMIT_ADDR  = 12'h144;
  localparam logic [ADDR_W-1:0] LAYER_BASE   = 12'h148;
  localparam logic [ADDR_W-1:0] LAYER_STRIDE = 12'h01C;

  // Field order within a layer window; the address offset follows it.
  typedef enum logic [2:0] {
    F_MODE   = 3'd0,
    F_BLEND  = 3'd1,
    F_ALPHA  = 3'd2,
    F_HOFF   = 3'd3,
    F_VOFF   = 3'd4,
    F_WIDTH  = 3'd5,
    F_HEIGHT = 3'd6
  } fieldE;

  typedef struct packed {
    logic       hit;
    logic [2:0] layer;
    fieldE      field;
  } layerHitT;

  // Strobes from control to datapath.
  typedef struct packed {
    logic [MAX_LAYERS-1:0] layerWr;
    fieldE                 field;
    logic                  apply;
  } strobeT;

  function automatic layerHitT decodeLayer(input logic [ADDR_W-1:0] addr,
                                           input int numLayers);
    layerHitT r;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] off;
    r = '{hit: 1'b0, layer: 3'd0, field: F_MODE};
    for (int l = 0; l < MAX_LAYERS; l++) begin
      base = LAYER_BASE + ADDR_W'(l) * LAYER_STRIDE;
      off  = addr - base;
      if (l < numLayers && addr >= base && off < LAYER_STRIDE) begin
        r.hit   = 1'b1;
        r.layer = 3'(l);
        r.field = fieldE'(off[4:2]);
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/mix_regs_ctrl.sv
module mix_regs_ctrl
  import mix_regs_pkg::*;
#(
  parameter int NUM_LAYERS = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              fieldStart,
  output strobeT            strb,
  output logic              pending
);

  logic [ADDR_W-1:0] wordAddr;
  layerHitT          hitL;
  logic              commitWr;
  logic              layerWr;
  logic              armed;

  assign wordAddr = {regAddr[ADDR_W-1:2], 2'b00};
  assign hitL     = decodeLayer(wordAddr, NUM_LAYERS);
  assign commitWr = regWrEn && (wordAddr == COMMIT_ADDR);
  assign layerWr  = regWrEn && hitL.hit;

  always_comb begin
    strb.layerWr = '0;
    if (layerWr) strb.layerWr[hitL.layer] = 1'b1;
    strb.field = hitL.field;
    strb.apply = fieldStart && (armed || commitWr);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
      armed   <= 1'b0;
    end else begin
      if (layerWr)         pending <= 1'b1;
      else if (strb.apply) pending <= 1'b0;
      if (strb.apply)      armed <= 1'b0;
      else if (commitWr)   armed <= 1'b1;
    end
  end

  p_pending_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.layerWr != '0) |=> pending)
    else $error("pending not set after layer write");

  p_commit_arms_r4: assert property (@(posedge clk) disable iff (!rstN)
    (commitWr && !fieldStart) |=> armed)
    else $error("commit did not arm");

  p_boundary_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    (fieldStart && armed && strb.layerWr == '0) |=> (!pending && !armed))
    else $error("boundary did not clear pending");

  p_same_cycle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (fieldStart && commitWr) |=> !armed)
    else $error("same-cycle commit left arming");

  p_no_field_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!fieldStart && pending) |=> pending)
    else $error("pending cleared without boundary");

endmodule

// File: rtl/mix_regs_dp.sv
module mix_regs_dp
  import mix_regs_pkg::*;
#(
  parameter int NUM_LAYERS  = 7,
  parameter int ALPHA_W     = 8,
  parameter int PIX_PER_CLK = 1
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  strobeT                            strb,
  input  logic [ADDR_W-1:0]                 regAddr,
  input  logic [31:0]                       regWrData,
  input  logic                              regRdEn,
  input  logic                              pending,
  input  logic                              fieldBusy,
  input  logic [NUM_LAYERS-1:0]             layerRunning,
  output logic [31:0]                       regRdData,
  output logic [NUM_LAYERS-1:0][2:0]        actMode,
  output logic [NUM_LAYERS-1:0][1:0]        actBlend,
  output logic [NUM_LAYERS-1:0][ALPHA_W-1:0] actAlpha,
  output logic [NUM_LAYERS-1:0][15:0]       actHOffset,
  output logic [NUM_LAYERS-1:0][15:0]       actVOffset,
  output logic [NUM_LAYERS-1:0][15:0]       actWidth,
  output logic [NUM_LAYERS-1:0][15:0]       actHeight
);

  localparam int RUN_LSB = 8;

  logic [NUM_LAYERS-1:0][2:0]         shdMode;
  logic [NUM_LAYERS-1:0][1:0]         shdBlend;
  logic [NUM_LAYERS-1:0][ALPHA_W-1:0] shdAlpha;
  logic [NUM_LAYERS-1:0][15:0]        shdHOffset;
  logic [NUM_LAYERS-1:0][15:0]        shdVOffset;
  logic [NUM_LAYERS-1:0][15:0]        shdWidth;
  logic [NUM_LAYERS-1:0][15:0]        shdHeight;

  logic [ADDR_W-1:0] wordAddr;
  layerHitT          rdHit;
  logic [31:0]       statusWord;
  logic [31:0]       rdNext;

  assign wordAddr = {regAddr[ADDR_W-1:2], 2'b00};
  assign rdHit    = decodeLayer(wordAddr, NUM_LAYERS);

  // Shadow bank: host writes.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shdMode <= '0; shdBlend <= '0; shdAlpha <= '0;
      shdHOffset <= '0; shdVOffset <= '0; shdWidth <= '0; shdHeight <= '0;
    end else begin
      for (int l = 0; l < NUM_LAYERS; l++) begin
        if (strb.layerWr[l]) begin
          case (strb.field)
            F_MODE:   shdMode[l]    <= regWrData[2:0];
            F_BLEND:  shdBlend[l]   <= regWrData[1:0];
            F_ALPHA:  shdAlpha[l]   <= regWrData[ALPHA_W-1:0];
            F_HOFF:   shdHOffset[l] <= regWrData[15:0];
            F_VOFF:   shdVOffset[l] <= regWrData[15:0];
            F_WIDTH:  shdWidth[l]   <= regWrData[15:0];
            F_HEIGHT: shdHeight[l]  <= regWrData[15:0];
            default: ;
          endcase
        end
      end
    end
  end

  // Active bank: whole-bank copy at an applying boundary.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actMode <= '0; actBlend <= '0; actAlpha <= '0;
      actHOffset <= '0; actVOffset <= '0; actWidth <= '0; actHeight <= '0;
    end else if (strb.apply) begin
      actMode    <= shdMode;
      actBlend   <= shdBlend;
      actAlpha   <= shdAlpha;
      actHOffset <= shdHOffset;
      actVOffset <= shdVOffset;
      actWidth   <= shdWidth;
      actHeight  <= shdHeight;
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[0] = fieldBusy;
    statusWord[1] = pending;
    statusWord[RUN_LSB +: NUM_LAYERS] = layerRunning;
  end

  always_comb begin
    rdNext = '0;
    if (rdHit.hit) begin
      for (int l = 0; l < NUM_LAYERS; l++) begin
        if (rdHit.layer == 3'(l)) begin
          case (rdHit.field)
            F_MODE:   rdNext = 32'(shdMode[l]);
            F_BLEND:  rdNext = 32'(shdBlend[l]);
            F_ALPHA:  rdNext = 32'(shdAlpha[l]);
            F_HOFF:   rdNext = 32'(shdHOffset[l]);
            F_VOFF:   rdNext = 32'(shdVOffset[l]);
            F_WIDTH:  rdNext = 32'(shdWidth[l]);
            F_HEIGHT: rdNext = 32'(shdHeight[l]);
            default:  rdNext = '0;
          endcase
        end
      end
    end else begin
      case (wordAddr)
        NLAYER_ADDR: rdNext = 32'(NUM_LAYERS + 1);
        PIXPAR_ADDR: rdNext = 32'(PIX_PER_CLK);
        STATUS_ADDR: rdNext = statusWord;
        default:     rdNext = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        regRdData <= '0;
    else if (regRdEn) regRdData <= rdNext;
  end

  p_active_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.apply |=> $stable({actMode, actBlend, actAlpha, actHOffset,
                             actVOffset, actWidth, actHeight}))
    else $error("active bank changed without boundary");

  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !regRdEn |=> $stable(regRdData))
    else $error("read data moved without read");

  p_status_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && wordAddr == STATUS_ADDR) |=>
      (regRdData[7:2] == '0 && regRdData[31:15] == '0))
    else $error("status reserved bits set");

endmodule

// File: rtl/mix_ctrl_regs.sv
module mix_ctrl_regs
  import mix_regs_pkg::*;
#(
  parameter int NUM_LAYERS  = 7,
  parameter int ALPHA_W     = 8,
  parameter int PIX_PER_CLK = 1
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [11:0]                        regAddr,
  input  logic                               regWrEn,
  input  logic [31:0]                        regWrData,
  input  logic                               regRdEn,
  output logic [31:0]                        regRdData,
  input  logic                               fieldStart,
  input  logic                               fieldBusy,
  input  logic [NUM_LAYERS-1:0]              layerRunning,
  output logic [NUM_LAYERS-1:0][2:0]         actMode,
  output logic [NUM_LAYERS-1:0][1:0]         actBlend,
  output logic [NUM_LAYERS-1:0][ALPHA_W-1:0] actAlpha,
  output logic [NUM_LAYERS-1:0][15:0]        actHOffset,
  output logic [NUM_LAYERS-1:0][15:0]        actVOffset,
  output logic [NUM_LAYERS-1:0][15:0]        actWidth,
  output logic [NUM_LAYERS-1:0][15:0]        actHeight
);

  strobeT strb;
  logic   pending;

  mix_regs_ctrl #(.NUM_LAYERS(NUM_LAYERS)) ctrl_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .fieldStart(fieldStart), .strb(strb), .pending(pending)
  );

  mix_regs_dp #(.NUM_LAYERS(NUM_LAYERS), .ALPHA_W(ALPHA_W),
                .PIX_PER_CLK(PIX_PER_CLK)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .regAddr(regAddr),
    .regWrData(regWrData), .regRdEn(regRdEn), .pending(pending),
    .fieldBusy(fieldBusy), .layerRunning(layerRunning),
    .regRdData(regRdData), .actMode(actMode), .actBlend(actBlend),
    .actAlpha(actAlpha), .actHOffset(actHOffset), .actVOffset(actVOffset),
    .actWidth(actWidth), .actHeight(actHeight)
  );

endmodule

// File: tb/mix_ctrl_regs_tb.sv
module mix_ctrl_regs_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NL  = 7;
  localparam int AW  = 8;
  localparam int PPC = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [11:0] regAddr = '0;
  logic regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic regRdEn = 1'b0;
  logic [31:0] regRdData;
  logic fieldStart = 1'b0;
  logic fieldBusy = 1'b0;
  logic [NL-1:0] layerRunning = '0;
  logic [NL-1:0][2:0]    actMode;
  logic [NL-1:0][1:0]    actBlend;
  logic [NL-1:0][AW-1:0] actAlpha;
  logic [NL-1:0][15:0]   actHOffset, actVOffset, actWidth, actHeight;

  always #(CLK_PERIOD/2) clk = ~clk;

  mix_ctrl_regs #(.NUM_LAYERS(NL), .ALPHA_W(AW), .PIX_PER_CLK(PPC)) dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .fieldStart(fieldStart), .fieldBusy(fieldBusy),
    .layerRunning(layerRunning), .actMode(actMode), .actBlend(actBlend),
    .actAlpha(actAlpha), .actHOffset(actHOffset), .actVOffset(actVOffset),
    .actWidth(actWidth), .actHeight(actHeight)
  );

  // Behavioural reference state
  int shd [NL][7];
  int act [NL][7];
  int mPending, mArmed;
  int rdExp;
  int checks, fails;
  bit done;

  function automatic int fieldMask(int k);
    case (k)
      0: return 32'h7;
      1: return 32'h3;
      2: return (1 << AW) - 1;
      default: return 32'hFFFF;
    endcase
  endfunction

  function automatic int layerAddr(int l, int k);
    return 'h148 + l * 'h1C + k * 4;
  endfunction

  function automatic int modelRead(int a);
    int w;
    w = a & 'hFFC;
    if (w == 'h000) return NL + 1;
    if (w == 'h004) return PPC;
    if (w == 'h140) return int'(fieldBusy) | (mPending << 1) | (int'(layerRunning) << 8);
    for (int l = 0; l < NL; l++)
      for (int k = 0; k < 7; k++)
        if (w == layerAddr(l, k)) return shd[l][k];
    return 0;
  endfunction

  task automatic modelStep();
    int w, lw, lh, kh, applyNow, commitNow;
    w = int'(regAddr) & 'hFFC;
    lh = 0; kh = 0; lw = 0;
    for (int l = 0; l < NL; l++)
      for (int k = 0; k < 7; k++)
        if (regWrEn && w == layerAddr(l, k)) begin lw = 1; lh = l; kh = k; end
    commitNow = (regWrEn && w == 'h144) ? 1 : 0;
    if (regRdEn) rdExp = modelRead(int'(regAddr));
    applyNow = (fieldStart && (mArmed || commitNow)) ? 1 : 0;
    if (applyNow)
      for (int l = 0; l < NL; l++)
        for (int k = 0; k < 7; k++) act[l][k] = shd[l][k];
    if (lw) shd[lh][kh] = int'(regWrData) & fieldMask(kh);
    if (lw) mPending = 1; else if (applyNow) mPending = 0;
    if (applyNow) mArmed = 0; else if (commitNow) mArmed = 1;
  endtask

  task automatic compare(string tag);
    int bad;
    bad = 0;
    checks++;
    if (int'(regRdData) != rdExp) begin
      bad = 1;
      $display("FAIL %s: regRdData actual=%h expected=%h", tag, regRdData, rdExp);
    end
    for (int l = 0; l < NL; l++) begin
      int got [7];
      got[0] = int'(actMode[l]);    got[1] = int'(actBlend[l]);
      got[2] = int'(actAlpha[l]);   got[3] = int'(actHOffset[l]);
      got[4] = int'(actVOffset[l]); got[5] = int'(actWidth[l]);
      got[6] = int'(actHeight[l]);
      for (int k = 0; k < 7; k++)
        if (got[k] != act[l][k] && bad == 0) begin
          bad = 1;
          $display("FAIL %s: layer %0d field %0d actual=%h expected=%h",
                   tag, l + 1, k, got[k], act[l][k]);
        end
    end
    if (bad) fails++;
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic wr(int a, int d, string tag);
    regAddr = 12'(a); regWrData = 32'(d); regWrEn = 1'b1;
    tick(tag);
    regWrEn = 1'b0;
  endtask

  task automatic rd(int a, string tag);
    regAddr = 12'(a); regRdEn = 1'b1;
    tick(tag);
    regRdEn = 1'b0;
  endtask

  task automatic field(string tag);
    fieldStart = 1'b1;
    tick(tag);
    fieldStart = 1'b0;
  endtask

  function automatic int pat(int l, int k, int s);
    return ((l + 1) * 4099 + k * 613 + s * 97) * 32'h9E3779B1;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; done = 0;
    mPending = 0; mArmed = 0; rdExp = 0;
    for (int l = 0; l < NL; l++)
      for (int k = 0; k < 7; k++) begin shd[l][k] = 0; act[l][k] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    compare("R1 reset");
    for (int l = 0; l < NL; l++)
      for (int k = 0; k < 7; k++) rd(layerAddr(l, k), "R1 reset readback");
    rd('h140, "R1 pending clear");

    // R2 write/read map with upper bits set, low address bits ignored
    for (int l = 0; l < NL; l++)
      for (int k = 0; k < 7; k++) wr(layerAddr(l, k) + (k % 4), pat(l, k, 0), "R2 write");
    for (int l = 0; l < NL; l++)
      for (int k = 0; k < 7; k++) rd(layerAddr(l, k), "R2 readback");
    rd('h140, "R3 pending set");

    // R12 boundary without commit
    field("R12 no commit");
    rd('h140, "R12 pending kept");

    // R4 commit with junk data, then idle
    wr('h144, 32'hDEADBEEF, "R4 commit");
    repeat (3) tick("R4 wait");
    rd('h140, "R4 still pending");
    field("R5 apply");
    rd('h140, "R5 pending cleared");
    field("R5 second boundary no change");

    // R6 commit in same cycle as boundary
    wr(layerAddr(2, 3), 32'h1234, "R6 write");
    regAddr = 12'h144; regWrData = '1; regWrEn = 1'b1; fieldStart = 1'b1;
    tick("R6 same cycle");
    regWrEn = 1'b0; fieldStart = 1'b0;
    rd('h140, "R6 pending cleared");

    // R7 layer write in the applying boundary cycle
    wr(layerAddr(4, 5), 32'h0F0F, "R7 pre write");
    wr('h144, 0, "R7 commit");
    regAddr = 12'(layerAddr(4, 5)); regWrData = 32'hABCD; regWrEn = 1'b1;
    fieldStart = 1'b1;
    tick("R7 write at boundary");
    regWrEn = 1'b0; fieldStart = 1'b0;
    rd('h140, "R7 pending stays");
    rd(layerAddr(4, 5), "R7 shadow holds new");
    wr('h144, 0, "R7 commit again");
    field("R7 second apply");

    // R8 status patterns
    for (int i = 0; i < 6; i++) begin
      fieldBusy = 1'(i);
      layerRunning = NL'(32'h5A >> i) ^ NL'(i * 19);
      rd('h140, "R8 status");
    end
    fieldBusy = 1'b0; layerRunning = '1;
    rd('h142, "R8 status low bits ignored");

    // R9 parameter words
    rd('h000, "R9 layer count");
    rd('h004, "R9 pixels per clock");

    // R10 unmapped / read-only
    rd('h100, "R10 unmapped read");
    rd('h148 + NL * 'h1C, "R10 past last layer");
    rd('hFFC, "R10 top address");
    wr('h000, 32'hFFFF_FFFF, "R10 ro write");
    wr('h140, 32'hFFFF_FFFF, "R10 status write");
    wr('h148 + NL * 'h1C, 32'hFFFF_FFFF, "R10 unmapped write");
    rd('h000, "R10 ro unchanged");
    rd('h140, "R10 pending not set");
    wr('h144, 0, "R10 commit");
    field("R10 apply unchanged");

    // R11 read holds without strobe
    rd(layerAddr(0, 0), "R11 read");
    for (int i = 0; i < 4; i++) begin
      regAddr = 12'(layerAddr(i, 3));
      tick("R11 hold");
    end

    // R3/R5 second round with new values
    for (int l = 0; l < NL; l++) wr(layerAddr(l, 6), pat(l, 6, 1), "R3 rewrite");
    wr('h144, 0, "R5 commit");
    field("R5 apply round two");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule